// File: doc/BRIEF.md
# I2C Target Line Front End

This block sits between the two open-drain wires of an I2C bus and the protocol logic of a target device. It cleans up the incoming clock and data levels by rejecting short spikes. It reports bus conditions and received bits as single-cycle strobes. It drives the data wire back onto the bus under timing rules that keep each bit valid around the clock edges. Byte assembly and address comparison belong to the layer above.

On the transmit side, the upper layer offers one bit through a valid/ready pair. While `tx_ready` is high, SCL is low and the data hold time has passed. During that window the block follows `tx_valid`/`tx_bit` on every cycle, so the pair may change freely. The value held in the last `tx_ready` cycle is the one on the wire for the following SCL high phase. Back-pressure runs the other way through `host_ready`. If it is low when SCL falls, the block holds SCL low. It lets SCL go only after `host_ready` returns and the data bit has been stable for a set number of cycles. Outputs are pull-down enables: a 1 drives the wire low.

Top module: `i2cf_frontend`

## Requirements
- R1: A change on either line input that lasts SPIKE_CYC clock cycles or fewer has no effect on any output. A change that lasts SPIKE_CYC+1 cycles is accepted.
- R2: `start_stb` pulses for one cycle when filtered SDA falls while filtered SCL is high. This covers both a first START and a repeated START that follows an SCL low phase with no STOP.
- R3: `stop_stb` pulses for one cycle when filtered SDA rises while filtered SCL is high.
- R4: `rx_stb` pulses for one cycle on each filtered SCL rising edge, and `rx_bit` carries the filtered SDA level in that cycle.
- R5: `sda_oe` does not change while filtered SCL is high, except for the release caused by a STOP.
- R6: After a filtered SCL fall, `sda_oe` keeps its old value for at least HOLD_CYC cycles. It then takes `tx_valid & ~tx_bit`: 1 pulls SDA low, and 0 (no bit offered, or bit 1) releases it.
- R7: A filtered SCL fall while `host_ready` is low makes `scl_oe` 1, so SCL stays low even after the controller releases it.
- R8: While stretching, `scl_oe` returns to 0 only after `host_ready` is high and `sda_oe` has been stable for SETUP_CYC cycles. A change of the offered bit restarts that count.
- R9: A STOP sets both `scl_oe` and `sda_oe` to 0 and ends any stretch.
- R10: During and right after reset, `scl_oe`, `sda_oe`, `tx_ready` and all strobes are 0.
- R11: A filtered SCL fall while `host_ready` is high does not assert `scl_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Raw level read from the SCL wire |
| sda_i | input | 1 | Raw level read from the SDA wire |
| scl_oe | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| start_stb | output | 1 | START or repeated START seen |
| stop_stb | output | 1 | STOP seen |
| rx_stb | output | 1 | SCL rising edge, bit sampled |
| rx_bit | output | 1 | Sampled SDA level, valid with rx_stb |
| host_ready | input | 1 | Upper layer can proceed; low at an SCL fall causes a stretch |
| tx_valid | input | 1 | A bit is offered for SDA |
| tx_bit | input | 1 | Offered bit value |
| tx_ready | output | 1 | Offered bit is being followed onto SDA |

## Verification
The assertions assume that SCL only falls after it has been high for some cycles. They also assume the bus rises only when no party pulls it low, so a STOP never coincides with the block's own pull on SDA. The exception is the one stimulus that deliberately drops the wired-AND model to inject a STOP during a stretch. The stimulus changes controller SDA only while SCL is low, apart from deliberate START, STOP and spike events. It waits for longer than the filter and hold latencies before each sample, so every event is seen cleanly.

// File: rtl/i2cf_pkg.sv
package i2cf_pkg;
  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } line_evt_t;
endpackage

// File: rtl/i2cf_spike_filter.sv
module i2cf_spike_filter #(
  parameter int SPIKE_CYC = 5,
  parameter int SYNC_LEN  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic level_o
);
  localparam int CW = $clog2(SPIKE_CYC + 1);

  logic [SYNC_LEN-1:0] sync_q;
  logic [CW-1:0]       cnt_q;
  logic                sync_out;

  assign sync_out = sync_q[SYNC_LEN-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= '1;
      cnt_q   <= '0;
      level_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_LEN-2:0], raw_i};
      if (sync_out == level_o) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(SPIKE_CYC)) begin
        level_o <= sync_out;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // R1: the filtered level only ever moves to the synchronized level
  a_r1_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o != $past(level_o)) |-> (level_o == $past(sync_out)));
  // R1: agreement with the synchronized level freezes the output
  a_r1_hold_when_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_out == level_o) |=> $stable(level_o));
endmodule

// File: rtl/i2cf_cond_detect.sv
module i2cf_cond_detect
  import i2cf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      scl_f,
  input  logic      sda_f,
  output line_evt_t evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  always_comb begin
    evt.start = scl_q & scl_f & sda_q & ~sda_f;
    evt.stop  = scl_q & scl_f & ~sda_q & sda_f;
    evt.rise  = ~scl_q & scl_f;
    evt.fall  = scl_q & ~scl_f;
  end

  // R2 R3 R4: conditions and clock edges never coincide
  a_r2_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt.start, evt.stop, evt.rise, evt.fall}));
  // R4: a rise strobe is never repeated on back-to-back cycles
  a_r4_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    evt.rise |=> !evt.rise);
endmodule

// File: rtl/i2cf_drive_ctrl.sv
module i2cf_drive_ctrl
  import i2cf_pkg::*;
#(
  parameter int HOLD_CYC  = 30,
  parameter int SETUP_CYC = 125
) (
  input  logic      clk,
  input  logic      rst_n,
  input  line_evt_t evt,
  input  logic      scl_f,
  input  logic      host_ready,
  input  logic      tx_valid,
  input  logic      tx_bit,
  output logic      tx_ready,
  output logic      sda_oe,
  output logic      scl_oe
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam int RW = $clog2(SETUP_CYC + 1);

  logic [HW-1:0] hold_cnt;
  logic          hold_done;
  logic [RW-1:0] rel_cnt;
  logic          sda_drv, nxt_drv;
  logic          stretch;

  always_comb begin
    nxt_drv = sda_drv;
    if (evt.stop)               nxt_drv = 1'b0;
    else if (!scl_f && hold_done) nxt_drv = tx_valid & ~tx_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_cnt  <= '0;
      hold_done <= 1'b0;
      sda_drv   <= 1'b0;
      stretch   <= 1'b0;
      rel_cnt   <= '0;
    end else begin
      if (scl_f) begin
        hold_cnt  <= '0;
        hold_done <= 1'b0;
      end else if (!hold_done) begin
        if (hold_cnt == HW'(HOLD_CYC - 1)) hold_done <= 1'b1;
        else                               hold_cnt  <= hold_cnt + HW'(1);
      end

      sda_drv <= nxt_drv;

      if (!stretch || !host_ready || !hold_done || (nxt_drv != sda_drv))
        rel_cnt <= '0;
      else if (rel_cnt != RW'(SETUP_CYC))
        rel_cnt <= rel_cnt + RW'(1);

      if (evt.stop)
        stretch <= 1'b0;
      else if (evt.fall && !host_ready)
        stretch <= 1'b1;
      else if (stretch && host_ready && rel_cnt == RW'(SETUP_CYC))
        stretch <= 1'b0;
    end
  end

  assign sda_oe   = sda_drv;
  assign scl_oe   = stretch;
  assign tx_ready = ~scl_f & hold_done;

  // R5: data pull is frozen while the clock is high
  a_r5_frozen_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && !evt.stop) |=> $stable(sda_oe));
  // R6: the data pull changes only after the hold window or on a STOP
  a_r6_hold_window: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> ($past(hold_done) || $past(evt.stop)));
  // R7: clock fall with upper layer busy starts a stretch
  a_r7_stretch_start: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.fall && !host_ready && !evt.stop) |=> scl_oe);
  // R8: a stretch ends only through ready plus a full setup count, or a STOP
  a_r8_release_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe) |-> ($past(evt.stop) ||
                       ($past(host_ready) && $past(rel_cnt) == RW'(SETUP_CYC))));
  // R9: STOP frees both wires
  a_r9_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    evt.stop |=> (!scl_oe && !sda_oe));
  // R11: no stretch when the upper layer is ready
  a_r11_no_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.fall && host_ready && !scl_oe) |=> !scl_oe);
endmodule

// File: rtl/i2cf_frontend.sv
module i2cf_frontend
  import i2cf_pkg::*;
#(
  parameter int SPIKE_CYC = 5,
  parameter int HOLD_CYC  = 30,
  parameter int SETUP_CYC = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_oe,
  output logic sda_oe,
  output logic start_stb,
  output logic stop_stb,
  output logic rx_stb,
  output logic rx_bit,
  input  logic host_ready,
  input  logic tx_valid,
  input  logic tx_bit,
  output logic tx_ready
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, filt_lines;
  line_evt_t         evt;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    i2cf_spike_filter #(.SPIKE_CYC(SPIKE_CYC), .SYNC_LEN(2)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (raw_lines[g]),
      .level_o(filt_lines[g])
    );
  end

  i2cf_cond_detect u_cond (
    .clk  (clk),
    .rst_n(rst_n),
    .scl_f(filt_lines[0]),
    .sda_f(filt_lines[1]),
    .evt  (evt)
  );

  i2cf_drive_ctrl #(.HOLD_CYC(HOLD_CYC), .SETUP_CYC(SETUP_CYC)) u_drive (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt),
    .scl_f     (filt_lines[0]),
    .host_ready(host_ready),
    .tx_valid  (tx_valid),
    .tx_bit    (tx_bit),
    .tx_ready  (tx_ready),
    .sda_oe    (sda_oe),
    .scl_oe    (scl_oe)
  );

  assign start_stb = evt.start;
  assign stop_stb  = evt.stop;
  assign rx_stb    = evt.rise;
  assign rx_bit    = filt_lines[1];
endmodule

// File: tb/sim_i2cf_frontend.sv
module sim_i2cf_frontend;
  localparam int CLK_PERIOD = 10;
  localparam int SPIKE = 3;
  localparam int HOLD  = 8;
  localparam int SETUP = 12;
  // rows: {controller sda, tx_valid, tx_bit}
  localparam logic [2:0] VEC [0:7] = '{3'b100, 3'b000, 3'b110, 3'b111,
                                       3'b011, 3'b110, 3'b010, 3'b101};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wired = 1'b1;
  logic host_ready = 1'b1, tx_valid = 1'b0, tx_bit = 1'b0;
  logic scl_i, sda_i, scl_oe, sda_oe, start_stb, stop_stb, rx_stb, rx_bit, tx_ready;
  int checks = 0, errors = 0;
  int n_start = 0, n_stop = 0, n_rx = 0;
  logic last_rx = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_i = wired ? (scl_m & ~scl_oe) : scl_m;
  assign sda_i = wired ? (sda_m & ~sda_oe) : sda_m;

  i2cf_frontend #(.SPIKE_CYC(SPIKE), .HOLD_CYC(HOLD), .SETUP_CYC(SETUP)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .start_stb(start_stb), .stop_stb(stop_stb),
    .rx_stb(rx_stb), .rx_bit(rx_bit), .host_ready(host_ready),
    .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_ready(tx_ready));

  always @(negedge clk) if (rst_n) begin
    if (start_stb) n_start++;
    if (stop_stb)  n_stop++;
    if (rx_stb) begin n_rx++; last_rx = rx_bit; end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int s0, p0, r0, n;
    logic exp_oe, exp_rx, prev;
    wait_cyc(5);
    // R10 reset state
    chk("R10 outputs in reset", {scl_oe, sda_oe, tx_ready, start_stb, stop_stb, rx_stb}, 0);
    rst_n = 1'b1;
    wait_cyc(2);
    chk("R10 outputs after reset", {scl_oe, sda_oe, tx_ready, start_stb, stop_stb, rx_stb}, 0);
    wait_cyc(20);

    // R1 spikes of SPIKE cycles are ignored
    s0 = n_start; p0 = n_stop; r0 = n_rx;
    sda_m = 1'b0; wait_cyc(SPIKE); sda_m = 1'b1; wait_cyc(20);
    chk("R1 sda spike no start", n_start, s0);
    chk("R1 sda spike no stop", n_stop, p0);
    scl_m = 1'b0; wait_cyc(SPIKE); scl_m = 1'b1; wait_cyc(20);
    chk("R1 scl spike no rx", n_rx, r0);
    // R1 a SPIKE+1 pulse is accepted: START then STOP (R2 R3)
    sda_m = 1'b0; wait_cyc(SPIKE + 1); sda_m = 1'b1; wait_cyc(20);
    chk("R1 R2 long pulse start", n_start, s0 + 1);
    chk("R1 R3 long pulse stop", n_stop, p0 + 1);

    // R2 START, then repeated START
    sda_m = 1'b0; wait_cyc(20);
    chk("R2 start", n_start, s0 + 2);
    scl_m = 1'b0; wait_cyc(20);
    sda_m = 1'b1; wait_cyc(20);
    scl_m = 1'b1; wait_cyc(20);
    sda_m = 1'b0; wait_cyc(20);
    chk("R2 repeated start", n_start, s0 + 3);
    chk("R2 no stop between", n_stop, p0 + 1);
    scl_m = 1'b0; wait_cyc(20);

    // table walk: R4 R5 R6 R11
    for (int i = 0; i < 8; i++) begin
      sda_m    = VEC[i][2];
      tx_valid = VEC[i][1];
      tx_bit   = VEC[i][0];
      exp_oe = VEC[i][1] & ~VEC[i][0];
      exp_rx = VEC[i][2] & ~exp_oe;
      wait_cyc(30);
      chk($sformatf("R6 row %0d sda_oe", i), sda_oe, exp_oe);
      chk($sformatf("R11 row %0d no stretch", i), scl_oe, 0);
      r0 = n_rx;
      scl_m = 1'b1; wait_cyc(20);
      chk($sformatf("R4 row %0d rx count", i), n_rx, r0 + 1);
      chk($sformatf("R4 row %0d rx bit", i), last_rx, exp_rx);
      tx_valid = ~tx_valid;
      wait_cyc(10);
      chk($sformatf("R5 row %0d frozen while high", i), sda_oe, exp_oe);
      scl_m = 1'b0; wait_cyc(30);
    end

    // R6 hold measurement: release first, then offer a low bit while SCL high
    tx_valid = 1'b0; sda_m = 1'b1; wait_cyc(30);
    scl_m = 1'b1; wait_cyc(20);
    tx_valid = 1'b1; tx_bit = 1'b0; wait_cyc(10);
    chk("R5 offered bit ignored while high", sda_oe, 0);
    scl_m = 1'b0;
    n = 0; prev = sda_oe;
    while (sda_oe == prev && n < 200) begin @(negedge clk); n++; end
    chk_rng("R6 hold after fall", n, HOLD + SPIKE + 3, HOLD + SPIKE + 6);
    chk("R6 pulls low after hold", sda_oe, 1);

    // R7 R8 stretch
    scl_m = 1'b1; wait_cyc(20);
    tx_valid = 1'b0; host_ready = 1'b0;
    scl_m = 1'b0; wait_cyc(40);
    chk("R7 stretch asserted", scl_oe, 1);
    r0 = n_rx;
    scl_m = 1'b1; wait_cyc(40);
    chk("R7 line held low", n_rx, r0);
    chk("R8 data released before release", sda_oe, 0);
    host_ready = 1'b1; wait_cyc(SETUP / 2);
    chk("R8 not released early", scl_oe, 1);
    tx_valid = 1'b1; tx_bit = 1'b0;
    n = 0;
    while (scl_oe && n < 200) begin @(negedge clk); n++; end
    chk_rng("R8 setup restart", n, SETUP + 1, SETUP + 3);
    chk("R8 data on line at release", sda_oe, 1);
    wait_cyc(20);
    chk("R8 rise after release", n_rx, r0 + 1);
    chk("R8 bit seen", last_rx, 0);

    // R9 STOP during stretch (wired model dropped)
    host_ready = 1'b0;
    scl_m = 1'b0; wait_cyc(40);
    chk("R9 precondition stretch", scl_oe, 1);
    wired = 1'b0; sda_m = 1'b0; wait_cyc(10);
    scl_m = 1'b1; wait_cyc(20);
    p0 = n_stop;
    sda_m = 1'b1; wait_cyc(20);
    chk("R9 R3 stop seen", n_stop, p0 + 1);
    chk("R9 scl released", scl_oe, 0);
    chk("R9 sda released", sda_oe, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule